// File: doc/BRIEF.md
# Exception Vector Address Generator

This block turns an exception code into the fetch address a processor core branches to when it takes that exception. The address is a table base plus an offset that depends on the exception. Software chooses one of two layouts at run time. The conventional layout spaces vectors 256 bytes apart, from a base of zero or of 0xFFF0_0000. The relocated layout packs vectors 8 bytes apart, from a base made of a table-select offset added to a window that follows an internal-memory base.

Four control fields select the layout: a prefix bit, a relocation enable, a table-select field and a 3-bit memory-base field. They are loaded through a small write port. A parameter sets the table-select field to one bit or two bits.

The core pulses a strobe with the exception code. It also flags whether the event is a system reset. A system reset clears the table-select field. A non-maskable interrupt that uses the same vector code leaves the field untouched. The vector address is returned one clock later together with a one-cycle valid pulse.

Top module: `excvec_gen`

## Requirements
- R1: After power-on reset, `vec_valid` is 0 and `vec_addr` is 0. The prefix bit resets to 1, and the relocation enable, table-select field and memory base reset to 0. So the first exception after reset uses the conventional layout with base 0xFFF0_0000.
- R2: Relocation is active only when both the prefix bit and the relocation enable are 1. When it is not active, the address is the base plus the code times 0x100. The base is 0xFFF0_0000 when the prefix bit is 1 and 0 when it is 0. For example, code 5 gives 0xFFF0_0500 or 0x0000_0500, and code 12 gives 0x0000_0C00.
- R3: Setting the relocation enable has no effect while the prefix bit is 0. The address keeps the conventional layout from base 0.
- R4: When relocation is active, the address is the memory base shifted left by 22 bits, plus the table base, plus the code times 8. For example, code 5 gives 0x28, code 28 gives 0xE0 and code 31 gives 0xF8. Code 2 with memory base 3 gives 0x00C0_0010.
- R5: The table base comes from the table-select field. In the one-bit variant, 0 selects 0 and 1 selects 0x8000. In the two-bit variant, 00 selects 0, 01 selects 0x1_0000, 10 selects 0x8_0000 and 11 selects 0x3F_E000.
- R6: A strobe with the system-reset flag set computes its vector with the table-select field taken as 0, and it clears the stored field. A strobe without the flag uses and keeps the stored field. With a select of 1 in the one-bit variant, code 1 therefore gives 0x0008 under system reset and 0x8008 otherwise.
- R7: `vec_valid` is high for exactly the one cycle after each cycle in which `exc_take` is high, and the address updates in that same cycle. Strobes on back-to-back cycles give back-to-back results. `vec_addr` holds its value while no strobe arrives.
- R8: When `cfg_we` is 1, the field picked by `cfg_sel` is loaded from `cfg_wdata`:
  - 0 loads the prefix bit from bit 0.
  - 1 loads the relocation enable from bit 0.
  - 2 loads the table-select field from its low bits.
  - 3 loads the memory base from bits 2:0.

  A write takes effect for strobes in later cycles. A strobe in the same cycle still sees the old value.
- R9: If a system-reset strobe and a write to the table-select field occur in the same cycle, the clear wins and the field ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cfg_we | input | 1 | Control field write enable |
| cfg_sel | input | 2 | Field select: 0 prefix, 1 relocation enable, 2 table select, 3 memory base |
| cfg_wdata | input | 3 | Write data |
| exc_take | input | 1 | Exception-taken strobe |
| exc_code | input | 5 | Exception index (conventional offset divided by 0x100) |
| exc_sysreset | input | 1 | The strobed exception is a system reset |
| vec_addr | output | 32 | Registered vector address |
| vec_valid | output | 1 | One-cycle pulse marking a new address |

## Verification
Every result is due exactly one clock after the strobe that caused it. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, which lies after the single rising edge that loads them. A configuration write lands on the rising edge after it is driven. It is therefore first visible to a strobe driven on the following falling edge, while a strobe driven in the same cycle must still see the old field. A behavioural model updated on each rising edge is compared with both width variants on every falling edge. Directed cases with hand-computed addresses cover each layout, each table select, the reset/NMI split and the write/strobe collisions.

// File: rtl/excvec_pkg.sv
`timescale 1ns/1ps
package excvec_pkg;
  localparam int unsigned VEC_W       = 32;
  localparam int unsigned CODE_W      = 5;
  localparam int unsigned CONV_SHIFT  = 8;
  localparam int unsigned RELOC_SHIFT = 3;

  typedef logic [VEC_W-1:0]  vec_t;
  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    SEL_PREFIX  = 2'd0,
    SEL_RELOC   = 2'd1,
    SEL_TABLE   = 2'd2,
    SEL_MEMBASE = 2'd3
  } cfg_sel_e;

  localparam vec_t CONV_HIGH_BASE = 32'hFFF0_0000;

  // Conventional layout: fixed base, 256-byte spacing.
  function automatic vec_t conv_vec(input logic prefix, input code_t code);
    vec_t base;
    base = prefix ? CONV_HIGH_BASE : '0;
    return base + (vec_t'(code) << CONV_SHIFT);
  endfunction

  // Table base for the single-bit select variant.
  function automatic vec_t tbase_1b(input logic sel);
    return sel ? 32'h0000_8000 : 32'h0000_0000;
  endfunction

  // Table base for the two-bit select variant.
  function automatic vec_t tbase_2b(input logic [1:0] sel);
    vec_t r;
    case (sel)
      2'b00:   r = 32'h0000_0000;
      2'b01:   r = 32'h0001_0000;
      2'b10:   r = 32'h0008_0000;
      default: r = 32'h003F_E000;
    endcase
    return r;
  endfunction

  // Relocated layout: window + table base, 8-byte spacing.
  function automatic vec_t reloc_vec(input vec_t window, input vec_t tbase, input code_t code);
    return window + tbase + (vec_t'(code) << RELOC_SHIFT);
  endfunction
endpackage

// File: rtl/excvec_cfg_regs.sv
`timescale 1ns/1ps
module excvec_cfg_regs
  import excvec_pkg::*;
#(
  parameter int unsigned OFF_W  = 1,
  parameter int unsigned MB_W   = 3,
  parameter int unsigned DATA_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              sysreset_take,
  output logic              prefix_q,
  output logic              reloc_q,
  output logic [OFF_W-1:0]  tsel_q,
  output logic [MB_W-1:0]   membase_q
);
  logic wr_prefix, wr_reloc, wr_tsel, wr_membase;

  assign wr_prefix  = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_PREFIX);
  assign wr_reloc   = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_RELOC);
  assign wr_tsel    = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_TABLE);
  assign wr_membase = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_MEMBASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prefix_q  <= 1'b1;
      reloc_q   <= 1'b0;
      membase_q <= '0;
    end else begin
      if (wr_prefix)  prefix_q  <= cfg_wdata[0];
      if (wr_reloc)   reloc_q   <= cfg_wdata[0];
      if (wr_membase) membase_q <= cfg_wdata[MB_W-1:0];
    end
  end

  // The system-reset clear takes priority over a same-cycle write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             tsel_q <= '0;
    else if (sysreset_take) tsel_q <= '0;
    else if (wr_tsel)       tsel_q <= cfg_wdata[OFF_W-1:0];
  end

  // R6 R9
  tsel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sysreset_take |=> (tsel_q == '0));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(prefix_q) && $stable(reloc_q) && $stable(membase_q)));

  // R8
  prefix_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd0) |=> (prefix_q == $past(cfg_wdata[0])));
endmodule

// File: rtl/excvec_addr_calc.sv
`timescale 1ns/1ps
module excvec_addr_calc
  import excvec_pkg::*;
#(
  parameter int unsigned OFF_W    = 1,
  parameter int unsigned MB_W     = 3,
  parameter int unsigned MB_SHIFT = 22
) (
  input  logic             prefix,
  input  logic             reloc_en,
  input  logic [OFF_W-1:0] tsel,
  input  logic [MB_W-1:0]  membase,
  input  code_t            code,
  input  logic             sysreset,
  output vec_t             next_addr,
  output logic             reloc_active
);
  logic [OFF_W-1:0] eff_tsel;
  vec_t             tbase;
  vec_t             window;

  assign reloc_active = prefix && reloc_en;
  assign eff_tsel     = sysreset ? '0 : tsel;
  assign window       = vec_t'(membase) << MB_SHIFT;

  generate
    if (OFF_W == 1) begin : g_tsel_1b
      assign tbase = tbase_1b(eff_tsel[0]);
    end else begin : g_tsel_2b
      assign tbase = tbase_2b(eff_tsel[1:0]);
    end
  endgenerate

  always_comb begin
    if (reloc_active) next_addr = reloc_vec(window, tbase, code);
    else              next_addr = conv_vec(prefix, code);
  end
endmodule

// File: rtl/excvec_out_reg.sv
`timescale 1ns/1ps
module excvec_out_reg
  import excvec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  vec_t next_addr,
  output vec_t vec_addr,
  output logic vec_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_addr  <= '0;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= take;
      if (take) vec_addr <= next_addr;
    end
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> vec_valid);

  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !vec_valid);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(vec_addr));
endmodule

// File: rtl/excvec_gen.sv
`timescale 1ns/1ps
module excvec_gen
  import excvec_pkg::*;
#(
  parameter int unsigned OFF_W    = 1,
  parameter int unsigned MB_W     = 3,
  parameter int unsigned MB_SHIFT = 22,
  localparam int unsigned CFG_W   = (MB_W > OFF_W) ? MB_W : OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              exc_take,
  input  logic [4:0]        exc_code,
  input  logic              exc_sysreset,
  output logic [31:0]       vec_addr,
  output logic              vec_valid
);
  logic             sysreset_take;
  logic             prefix_q, reloc_q;
  logic [OFF_W-1:0] tsel_q;
  logic [MB_W-1:0]  membase_q;
  vec_t             next_addr;
  logic             reloc_active;

  assign sysreset_take = exc_take && exc_sysreset;

  excvec_cfg_regs #(.OFF_W(OFF_W), .MB_W(MB_W), .DATA_W(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .sysreset_take(sysreset_take),
    .prefix_q(prefix_q), .reloc_q(reloc_q), .tsel_q(tsel_q), .membase_q(membase_q)
  );

  excvec_addr_calc #(.OFF_W(OFF_W), .MB_W(MB_W), .MB_SHIFT(MB_SHIFT)) u_calc (
    .prefix(prefix_q), .reloc_en(reloc_q), .tsel(tsel_q), .membase(membase_q),
    .code(exc_code), .sysreset(exc_sysreset),
    .next_addr(next_addr), .reloc_active(reloc_active)
  );

  excvec_out_reg u_out (
    .clk(clk), .rst_n(rst_n), .take(exc_take), .next_addr(next_addr),
    .vec_addr(vec_addr), .vec_valid(vec_valid)
  );

  // R2
  conv_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !reloc_active) |=> (vec_addr[12:0] == {$past(exc_code), 8'h00}));

  // R3
  low_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !prefix_q) |=> (vec_addr[31:13] == '0));

  // R4
  reloc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && reloc_active) |=> (vec_addr[7:0] == {$past(exc_code), 3'b000}));
endmodule

// File: tb/test_excvec_gen.sv
`timescale 1ns/1ps
module test_excvec_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [2:0]  cfg_wdata = 3'd0;
  logic        exc_take = 1'b0;
  logic [4:0]  exc_code = 5'd0;
  logic        exc_sysreset = 1'b0;
  logic [31:0] addr_n, addr_w;
  logic        valid_n, valid_w;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  excvec_gen #(.OFF_W(1)) i_excvec_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .exc_take(exc_take), .exc_code(exc_code), .exc_sysreset(exc_sysreset),
    .vec_addr(addr_n), .vec_valid(valid_n));

  excvec_gen #(.OFF_W(2)) i_excvec_gen_wide (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .exc_take(exc_take), .exc_code(exc_code), .exc_sysreset(exc_sysreset),
    .vec_addr(addr_w), .vec_valid(valid_w));

  // Behavioural reference model
  bit          m_pre, m_rel, m_valid;
  int          m_tsel, m_mb;
  logic [31:0] m_addr_n, m_addr_w;

  function automatic logic [31:0] model_addr(bit pre, bit rel, int tb, int mb, int code);
    if (pre && rel) return 32'(mb * 4194304 + tb + code * 8);
    return (pre ? 32'hFFF0_0000 : 32'h0) + 32'(code * 256);
  endfunction

  function automatic int tb_narrow(int sel);
    return (sel % 2 == 1) ? 32768 : 0;
  endfunction

  function automatic int tb_wide(int sel);
    case (sel)
      0: return 0;
      1: return 65536;
      2: return 524288;
      default: return 4186112;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre <= 1'b1; m_rel <= 1'b0; m_tsel <= 0; m_mb <= 0;
      m_valid <= 1'b0; m_addr_n <= '0; m_addr_w <= '0;
    end else begin
      int eff;
      eff = exc_sysreset ? 0 : m_tsel;
      m_valid <= exc_take;
      if (exc_take) begin
        m_addr_n <= model_addr(m_pre, m_rel, tb_narrow(eff), m_mb, int'(exc_code));
        m_addr_w <= model_addr(m_pre, m_rel, tb_wide(eff), m_mb, int'(exc_code));
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_pre <= cfg_wdata[0];
          2'd1: m_rel <= cfg_wdata[0];
          2'd2: m_tsel <= int'(cfg_wdata[1:0]);
          default: m_mb <= int'(cfg_wdata);
        endcase
      end
      if (exc_take && exc_sysreset) m_tsel <= 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // R7: every cycle, both variants against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 narrow valid", 32'(valid_n), 32'(m_valid));
      chk("R7 wide valid", 32'(valid_w), 32'(m_valid));
      chk("R7 narrow addr", addr_n, m_addr_n);
      chk("R7 wide addr", addr_w, m_addr_w);
    end
  end

  task automatic cfg(input logic [1:0] sel, input logic [2:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fire(input logic [4:0] code, input bit sr,
                      input logic [31:0] exp_n, input logic [31:0] exp_w, input string tag);
    @(negedge clk);
    exc_take = 1'b1; exc_code = code; exc_sysreset = sr;
    @(negedge clk);
    exc_take = 1'b0; exc_sysreset = 1'b0;
    chk({tag, " valid"}, 32'(valid_n & valid_w), 32'd1);
    chk({tag, " narrow"}, addr_n, exp_n);
    chk({tag, " wide"}, addr_w, exp_w);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid in reset", 32'(valid_n | valid_w), 32'd0);
    chk("R1 addr in reset", addr_n | addr_w, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(valid_n | valid_w), 32'd0);
    fire(5'd5, 1'b0, 32'hFFF0_0500, 32'hFFF0_0500, "R1 R2 first vector");
    // R7 pulse ends, address held
    @(negedge clk);
    chk("R7 pulse one cycle", 32'(valid_n | valid_w), 32'd0);
    chk("R7 addr held", addr_n, 32'hFFF0_0500);

    cfg(2'd0, 3'd0);
    fire(5'd12, 1'b0, 32'h0000_0C00, 32'h0000_0C00, "R2 low base");
    cfg(2'd1, 3'd1);
    fire(5'd5, 1'b0, 32'h0000_0500, 32'h0000_0500, "R3 enable without prefix");
    cfg(2'd0, 3'd1);
    fire(5'd5, 1'b0, 32'h0000_0028, 32'h0000_0028, "R4 relocated");
    fire(5'd28, 1'b0, 32'h0000_00E0, 32'h0000_00E0, "R4 data breakpoint");
    fire(5'd31, 1'b0, 32'h0000_00F8, 32'h0000_00F8, "R4 last vector");
    cfg(2'd3, 3'd3);
    fire(5'd2, 1'b0, 32'h00C0_0010, 32'h00C0_0010, "R4 memory base");

    cfg(2'd2, 3'd1);
    fire(5'd5, 1'b0, 32'h00C0_8028, 32'h00C1_0028, "R5 select 1");
    cfg(2'd2, 3'd3);
    fire(5'd5, 1'b0, 32'h00C0_8028, 32'h00FF_E028, "R5 select 3");
    cfg(2'd2, 3'd2);
    fire(5'd5, 1'b0, 32'h00C0_0028, 32'h00C8_0028, "R5 select 2");

    cfg(2'd3, 3'd0);
    cfg(2'd2, 3'd1);
    fire(5'd1, 1'b0, 32'h0000_8008, 32'h0001_0008, "R6 NMI keeps select");
    fire(5'd1, 1'b0, 32'h0000_8008, 32'h0001_0008, "R6 NMI select retained");
    fire(5'd1, 1'b1, 32'h0000_0008, 32'h0000_0008, "R6 system reset");
    fire(5'd5, 1'b0, 32'h0000_0028, 32'h0000_0028, "R6 select cleared");

    // R9: clear beats a same-cycle write
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 3'd1;
    exc_take = 1'b1; exc_code = 5'd1; exc_sysreset = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; exc_take = 1'b0; exc_sysreset = 1'b0;
    chk("R9 reset vector", addr_n, 32'h0000_0008);
    fire(5'd5, 1'b0, 32'h0000_0028, 32'h0000_0028, "R9 write lost");

    // R8: a strobe in the write cycle sees the old prefix
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 3'd0;
    exc_take = 1'b1; exc_code = 5'd5;
    @(negedge clk);
    cfg_we = 1'b0; exc_take = 1'b0;
    chk("R8 old value in write cycle", addr_w, 32'h0000_0028);
    fire(5'd5, 1'b0, 32'h0000_0500, 32'h0000_0500, "R8 new value next strobe");
    cfg(2'd0, 3'd1);

    // R7: back-to-back strobes
    @(negedge clk);
    exc_take = 1'b1; exc_code = 5'd3;
    @(negedge clk);
    exc_code = 5'd4;
    chk("R7 back-to-back first", addr_n, 32'h0000_0018);
    @(negedge clk);
    exc_take = 1'b0;
    chk("R7 back-to-back second", addr_n, 32'h0000_0020);
    chk("R7 back-to-back valid", 32'(valid_n), 32'd1);

    // Mixed stimulus against the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      cfg_we       = ($urandom % 4) == 0;
      cfg_sel      = 2'($urandom);
      cfg_wdata    = 3'($urandom);
      exc_take     = ($urandom % 2) == 0;
      exc_code     = 5'($urandom);
      exc_sysreset = ($urandom % 6) == 0;
    end
    @(negedge clk);
    cfg_we = 1'b0; exc_take = 1'b0; exc_sysreset = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule